// File: doc/BRIEF.md
# Lane Fault Column Forwarder

This block sits in one sublayer of a four-lane receive path that carries one byte and one control bit per lane per cycle. Columns from the sublayer below are passed up toward the MAC unchanged while everything is healthy. When the receive path is not healthy, the columns are replaced by a local-fault column. The path is unhealthy when signal detect from below is missing, or when this sublayer reports loss of signal, loss of lock, receive loss of sync or transmit-side loss of sync. Fault indications therefore accumulate as they travel up the chain. An in-band fault generated lower down reaches the MAC untouched, and a fault found here is added on top.

Local and remote fault share a single code byte and are told apart only by which lane pair carries it. Remote fault puts the code on lanes 0 and 1. Local fault puts it on lanes 2 and 3, or on all four lanes when the lane-mix-up-tolerant mode is selected. The remaining lanes carry a K or R control filler. The block also watches the incoming columns. It raises a sticky flag for each fault kind once two identical fault columns arrive back to back, and drops the flag after a long run without that column. It drives a registered out-of-band local-fault level and a link-good level.

Top module: `lff_forwarder`

## Requirements
- R1: `local_fault_o` is, one cycle later, the OR of `below_lf_i`, a low `sig_detect_i`, `los_i`, `lol_i`, `rx_sync_loss_i` and `tx_sync_loss_i`.
- R2: The upward lanes follow the input one cycle later. Data and control are copied unchanged, including an in-band fault column from below. This holds when `sig_detect_i` is 1 and none of `los_i`, `lol_i`, `rx_sync_loss_i`, `tx_sync_loss_i` is set.
- R3: Replacement applies when `sig_detect_i` is 0 or any of those four detectors is set. The next cycle's column then has all four control bits set, code 0x9C on lanes 2 and 3, and filler 0xBC on lanes 0 and 1 when `cfg_lf_all_i` is 0. Lane n occupies data bits [8n+7:8n] and control bit n.
- R4: When replacing with `cfg_lf_all_i` = 1, all four lanes carry 0x9C.
- R5: `link_good_o` is, one cycle later, `sig_detect_i` AND NOT (`los_i` OR `lol_i` OR `rx_sync_loss_i`). Transmit-side sync loss does not affect it.
- R6: An incoming remote-fault column has all control bits set, 0x9C on lanes 0 and 1, and 0xBC or 0x7C on each of lanes 2 and 3. `rx_rf_seen_o` rises after two such columns in consecutive cycles. One isolated column does not raise it.
- R7: An incoming local-fault column has all control bits set, 0x9C on lanes 2 and 3, and either 0xBC or 0x7C on each of lanes 0 and 1, or 0x9C on all four lanes. `rx_lf_seen_o` rises after two consecutive such columns and not after one.
- R8: A raised flag falls after 64 consecutive columns that are not its own kind. Any column of its kind restarts that count.
- R9: While synchronous reset `rst` is high, the outputs are the lane-pair local-fault column of R3, `local_fault_o` = 1, `link_good_o` = 0, and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_data_i | input | 32 | Lane bytes from below, lane 0 in the low byte |
| rx_ctrl_i | input | 4 | Per-lane control flags from below |
| sig_detect_i | input | 1 | Healthy-signal indication from the sublayer below |
| below_lf_i | input | 1 | Out-of-band local fault from the sublayer below |
| los_i | input | 1 | Loss of signal detected here |
| lol_i | input | 1 | Loss of lock detected here |
| rx_sync_loss_i | input | 1 | Receive loss of sync detected here |
| tx_sync_loss_i | input | 1 | Transmit-side loss of sync detected here |
| cfg_lf_all_i | input | 1 | Emit local fault on all four lanes instead of lanes 2-3 |
| up_data_o | output | 32 | Lane bytes toward the MAC |
| up_ctrl_o | output | 4 | Per-lane control flags toward the MAC |
| local_fault_o | output | 1 | Out-of-band local fault toward the MAC |
| link_good_o | output | 1 | Receive link good |
| rx_lf_seen_o | output | 1 | Local-fault columns arriving from below |
| rx_rf_seen_o | output | 1 | Remote-fault columns arriving from below |

## Verification
The bench covers the case where a healthy path forwards an in-band local-fault column. A design that regenerated it, or dropped it, would break the pass-through rule. It checks that each fault kind is told apart only by lane pair, with both fillers and the all-lanes placement. Swapping the lane pairs would raise the wrong flag. It checks that a single isolated fault column raises nothing. It also checks the exact quiet-count boundary: the flag must still be high after 63 clean columns and low after the 64th, and one fault column in the middle must restart the count. An off-by-one counter or a missing restart would show at that edge.

// File: rtl/lff_pkg.sv
package lff_pkg;

    // Classification of one incoming column
    typedef enum logic [1:0] {
        COL_NORMAL = 2'd0,
        COL_LF     = 2'd1,
        COL_RF     = 2'd2
    } col_class_e;

    localparam int NUM_KINDS = 2;

endpackage

// File: rtl/lff_col_classify.sv
module lff_col_classify
    import lff_pkg::*;
#(
    parameter int LANES = 4,
    parameter int BYTE_W = 8,
    parameter logic [BYTE_W-1:0] FAULT_CODE = 8'h9C,
    parameter logic [BYTE_W-1:0] FILL_K = 8'hBC,
    parameter logic [BYTE_W-1:0] FILL_R = 8'h7C
) (
    input  logic [LANES*BYTE_W-1:0] data_i,
    input  logic [LANES-1:0]        ctrl_i,
    output col_class_e              class_o
);
    localparam int HALF = LANES / 2;

    logic [LANES-1:0] is_code;
    logic [LANES-1:0] is_fill;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [BYTE_W-1:0] lane_byte;
        assign lane_byte  = data_i[i*BYTE_W +: BYTE_W];
        assign is_code[i] = ctrl_i[i] && (lane_byte == FAULT_CODE);
        assign is_fill[i] = ctrl_i[i] && (lane_byte == FILL_K || lane_byte == FILL_R);
    end

    logic all_ctrl, lo_code, hi_code, lo_fill, hi_fill;

    always_comb begin
        all_ctrl = &ctrl_i;
        lo_code  = &is_code[HALF-1:0];
        hi_code  = &is_code[LANES-1:HALF];
        lo_fill  = &is_fill[HALF-1:0];
        hi_fill  = &is_fill[LANES-1:HALF];
        if (all_ctrl && lo_code && hi_fill) begin
            class_o = COL_RF;
        end else if (all_ctrl && hi_code && (lo_fill || lo_code)) begin
            class_o = COL_LF;
        end else begin
            class_o = COL_NORMAL;
        end
    end

endmodule

// File: rtl/lff_fault_flag.sv
module lff_fault_flag #(
    parameter int QUIET_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic seen_i,   // this cycle's column is of this kind
    input  logic pair_i,   // and the previous one was too
    output logic flag_o
);
    localparam int CNT_W = $clog2(QUIET_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(QUIET_CYCLES - 1);

    typedef struct packed {
        logic             flag;
        logic [CNT_W-1:0] cnt;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (seen_i) begin
            st_d.cnt = '0;
            if (pair_i) begin
                st_d.flag = 1'b1;
            end
        end else if (st_q.flag) begin
            if (st_q.cnt == LAST) begin
                st_d.flag = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/lff_lane_mux.sv
module lff_lane_mux #(
    parameter int LANES = 4,
    parameter int BYTE_W = 8,
    parameter logic [BYTE_W-1:0] FAULT_CODE = 8'h9C,
    parameter logic [BYTE_W-1:0] FILL_K = 8'hBC
) (
    input  logic [LANES*BYTE_W-1:0] rx_data_i,
    input  logic [LANES-1:0]        rx_ctrl_i,
    input  logic                    replace_i,
    input  logic                    all_lanes_i,
    output logic [LANES*BYTE_W-1:0] data_o,
    output logic [LANES-1:0]        ctrl_o,
    output logic [LANES*BYTE_W-1:0] pair_pat_o
);
    localparam int HALF = LANES / 2;

    logic [LANES*BYTE_W-1:0] fault_pat;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i >= HALF) begin : g_hi
            assign fault_pat[i*BYTE_W +: BYTE_W]  = FAULT_CODE;
            assign pair_pat_o[i*BYTE_W +: BYTE_W] = FAULT_CODE;
        end else begin : g_lo
            assign fault_pat[i*BYTE_W +: BYTE_W]  = all_lanes_i ? FAULT_CODE : FILL_K;
            assign pair_pat_o[i*BYTE_W +: BYTE_W] = FILL_K;
        end
    end

    always_comb begin
        if (replace_i) begin
            data_o = fault_pat;
            ctrl_o = '1;
        end else begin
            data_o = rx_data_i;
            ctrl_o = rx_ctrl_i;
        end
    end

endmodule

// File: rtl/lff_forwarder.sv
module lff_forwarder
    import lff_pkg::*;
#(
    parameter int LANES = 4,
    parameter int BYTE_W = 8,
    parameter int QUIET_CYCLES = 64,
    parameter logic [BYTE_W-1:0] FAULT_CODE = 8'h9C,
    parameter logic [BYTE_W-1:0] FILL_K = 8'hBC,
    parameter logic [BYTE_W-1:0] FILL_R = 8'h7C
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES*BYTE_W-1:0] rx_data_i,
    input  logic [LANES-1:0]        rx_ctrl_i,
    input  logic                    sig_detect_i,
    input  logic                    below_lf_i,
    input  logic                    los_i,
    input  logic                    lol_i,
    input  logic                    rx_sync_loss_i,
    input  logic                    tx_sync_loss_i,
    input  logic                    cfg_lf_all_i,
    output logic [LANES*BYTE_W-1:0] up_data_o,
    output logic [LANES-1:0]        up_ctrl_o,
    output logic                    local_fault_o,
    output logic                    link_good_o,
    output logic                    rx_lf_seen_o,
    output logic                    rx_rf_seen_o
);
    localparam int DATA_W = LANES * BYTE_W;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  ctrl;
        logic              lf;
        logic              good;
        col_class_e        prev;
    } fwd_st_t;

    fwd_st_t st_d, st_q;

    logic              rx_locked;
    logic              replace;
    col_class_e        cur_class;
    logic [DATA_W-1:0] mux_data;
    logic [LANES-1:0]  mux_ctrl;
    logic [DATA_W-1:0] pair_pat;
    logic [NUM_KINDS-1:0] kind_flag;

    always_comb begin
        rx_locked = sig_detect_i && !los_i && !lol_i && !rx_sync_loss_i;
        replace   = !rx_locked || tx_sync_loss_i;
    end

    lff_col_classify #(
        .LANES(LANES), .BYTE_W(BYTE_W),
        .FAULT_CODE(FAULT_CODE), .FILL_K(FILL_K), .FILL_R(FILL_R)
    ) u_classify (
        .data_i  (rx_data_i),
        .ctrl_i  (rx_ctrl_i),
        .class_o (cur_class)
    );

    lff_lane_mux #(
        .LANES(LANES), .BYTE_W(BYTE_W),
        .FAULT_CODE(FAULT_CODE), .FILL_K(FILL_K)
    ) u_mux (
        .rx_data_i   (rx_data_i),
        .rx_ctrl_i   (rx_ctrl_i),
        .replace_i   (replace),
        .all_lanes_i (cfg_lf_all_i),
        .data_o      (mux_data),
        .ctrl_o      (mux_ctrl),
        .pair_pat_o  (pair_pat)
    );

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        col_class_e kind;
        assign kind = (k == 0) ? COL_LF : COL_RF;
        lff_fault_flag #(.QUIET_CYCLES(QUIET_CYCLES)) u_flag (
            .clk    (clk),
            .rst    (rst),
            .seen_i (cur_class == kind),
            .pair_i (st_q.prev == kind),
            .flag_o (kind_flag[k])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.data = mux_data;
        st_d.ctrl = mux_ctrl;
        st_d.lf   = replace || below_lf_i;
        st_d.good = rx_locked;
        st_d.prev = cur_class;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.data <= pair_pat;
            st_q.ctrl <= '1;
            st_q.lf   <= 1'b1;
            st_q.good <= 1'b0;
            st_q.prev <= COL_NORMAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign up_data_o     = st_q.data;
    assign up_ctrl_o     = st_q.ctrl;
    assign local_fault_o = st_q.lf;
    assign link_good_o   = st_q.good;
    assign rx_lf_seen_o  = kind_flag[0];
    assign rx_rf_seen_o  = kind_flag[1];

endmodule

// File: rtl/lff_forwarder_chk.sv
module lff_forwarder_chk #(
    parameter int LANES = 4,
    parameter int BYTE_W = 8,
    parameter logic [BYTE_W-1:0] FAULT_CODE = 8'h9C
) (
    input logic                    clk,
    input logic                    rst,
    input logic [LANES*BYTE_W-1:0] rx_data_i,
    input logic [LANES-1:0]        rx_ctrl_i,
    input logic                    sig_detect_i,
    input logic                    below_lf_i,
    input logic                    los_i,
    input logic                    lol_i,
    input logic                    rx_sync_loss_i,
    input logic                    tx_sync_loss_i,
    input logic                    cfg_lf_all_i,
    input logic [LANES*BYTE_W-1:0] up_data_o,
    input logic [LANES-1:0]        up_ctrl_o,
    input logic                    local_fault_o,
    input logic                    link_good_o,
    input logic                    rx_lf_seen_o,
    input logic                    rx_rf_seen_o
);
    localparam int DW = LANES * BYTE_W;

    logic bad_in;
    assign bad_in = !sig_detect_i || los_i || lol_i || rx_sync_loss_i || tx_sync_loss_i;

    AST_FAULT_COLUMN: assert property (@(posedge clk) disable iff (rst)
        bad_in |=> (&up_ctrl_o) && up_data_o[DW-1:DW/2] == {(LANES/2){FAULT_CODE}}); // R3

    AST_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        (bad_in && cfg_lf_all_i) |=> up_data_o == {LANES{FAULT_CODE}}); // R4

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        !bad_in |=> up_data_o == $past(rx_data_i) && up_ctrl_o == $past(rx_ctrl_i)); // R2

    AST_LF_RAISED: assert property (@(posedge clk) disable iff (rst)
        (below_lf_i || bad_in) |=> local_fault_o); // R1

    AST_GOOD_NEEDS_DETECT: assert property (@(posedge clk) disable iff (rst)
        link_good_o |-> $past(sig_detect_i)); // R5

    AST_RF_RISE_CTRL: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_rf_seen_o) |-> $past(&rx_ctrl_i)); // R6

    AST_LF_RISE_CTRL: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_lf_seen_o) |-> $past(&rx_ctrl_i)); // R7

endmodule

bind lff_forwarder lff_forwarder_chk #(
    .LANES(LANES), .BYTE_W(BYTE_W), .FAULT_CODE(FAULT_CODE)
) u_chk (.*);

// File: tb/lff_forwarder_tb.sv
module lff_forwarder_tb;
    localparam int CLK_PERIOD = 10;

    localparam logic [31:0] P_LF  = 32'h9C9CBCBC;
    localparam logic [31:0] P_ALL = 32'h9C9C9C9C;
    localparam logic [31:0] P_RF  = 32'hBCBC9C9C;
    localparam logic [31:0] P_RFR = 32'h7CBC9C9C;
    localparam logic [31:0] P_LFR = 32'h9C9C7CBC;
    localparam logic [31:0] NORM  = 32'h11223344;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] rx_data;
    logic [3:0]  rx_ctrl;
    logic        sd, blf, los, lol, rsl, tsl, all;
    logic [31:0] up_data;
    logic [3:0]  up_ctrl;
    logic        lf, good, lf_seen, rf_seen;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lff_forwarder u_dut (
        .clk(clk), .rst(rst), .rx_data_i(rx_data), .rx_ctrl_i(rx_ctrl),
        .sig_detect_i(sd), .below_lf_i(blf), .los_i(los), .lol_i(lol),
        .rx_sync_loss_i(rsl), .tx_sync_loss_i(tsl), .cfg_lf_all_i(all),
        .up_data_o(up_data), .up_ctrl_o(up_ctrl), .local_fault_o(lf),
        .link_good_o(good), .rx_lf_seen_o(lf_seen), .rx_rf_seen_o(rf_seen)
    );

    typedef struct packed {
        logic sd, los, lol, rsl, tsl, blf, all;
        logic [31:0] d;
        logic [3:0]  c;
        logic [31:0] ed;
        logic [3:0]  ec;
        logic elf, egood;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // sd los lol rsl tsl blf all  data        ctrl    exp data    exp ctrl lf good
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, NORM, 4'h0, NORM, 4'h0, 1'b0,1'b1},         // R2 R5
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 32'h070707FB, 4'h1, 32'h070707FB, 4'h1, 1'b0,1'b1}, // R2
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, P_LF, 4'hF, P_LF, 4'hF, 1'b0,1'b1},         // R2 in-band LF
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, NORM, 4'h0, P_LF, 4'hF, 1'b1,1'b0},         // R3
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, NORM, 4'h0, P_ALL, 4'hF, 1'b1,1'b0},        // R4
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, NORM, 4'h2, P_LF, 4'hF, 1'b1,1'b0},         // R3
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, NORM, 4'h0, P_LF, 4'hF, 1'b1,1'b1},         // R3 R5
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, NORM, 4'h0, NORM, 4'h0, 1'b1,1'b1},         // R1
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, NORM, 4'h0, P_ALL, 4'hF, 1'b1,1'b0}         // R4 R5
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_col(input logic [31:0] d, input logic [3:0] c);
        rx_data = d;
        rx_ctrl = c;
    endtask

    task automatic run_quiet(input int n);
        drive_col(NORM, 4'h0);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        sd = 1'b1; blf = 1'b0; los = 1'b0; lol = 1'b0;
        rsl = 1'b0; tsl = 1'b0; all = 1'b1;
        drive_col(NORM, 4'h0);
        step(); step(); step();
        // R9 reset state, pair placement even with all-lanes mode selected
        check("R9", "rst data", up_data, P_LF);
        check("R9", "rst ctrl", 32'(up_ctrl), 32'hF);
        check("R9", "rst lf", 32'(lf), 32'd1);
        check("R9", "rst good", 32'(good), 32'd0);
        check("R9", "rst flags", {30'd0, lf_seen, rf_seen}, 32'd0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            sd = VECS[v].sd; los = VECS[v].los; lol = VECS[v].lol;
            rsl = VECS[v].rsl; tsl = VECS[v].tsl; blf = VECS[v].blf;
            all = VECS[v].all;
            drive_col(VECS[v].d, VECS[v].c);
            step();
            check("R2/R3/R4", "data", up_data, VECS[v].ed);
            check("R2/R3/R4", "ctrl", 32'(up_ctrl), 32'(VECS[v].ec));
            check("R1", "local fault", 32'(lf), 32'(VECS[v].elf));
            check("R5", "link good", 32'(good), 32'(VECS[v].egood));
        end
        sd = 1'b1; los = 1'b0; lol = 1'b0; rsl = 1'b0; tsl = 1'b0; blf = 1'b0; all = 1'b0;

        // R7 isolated LF column (vector table) raised nothing
        check("R7", "single lf column", 32'(lf_seen), 32'd0);

        // R6 isolated RF column
        run_quiet(2);
        drive_col(P_RF, 4'hF); step();
        run_quiet(1);
        check("R6", "single rf column", 32'(rf_seen), 32'd0);

        // R6 two consecutive RF columns (R filler on lane 3)
        drive_col(P_RF, 4'hF); step();
        drive_col(P_RFR, 4'hF); step();
        check("R6", "rf flag set", 32'(rf_seen), 32'd1);
        check("R6", "lf stays clear", 32'(lf_seen), 32'd0);

        // R8 quiet boundary
        run_quiet(63);
        check("R8", "rf after 63 quiet", 32'(rf_seen), 32'd1);
        run_quiet(1);
        check("R8", "rf after 64 quiet", 32'(rf_seen), 32'd0);

        // R7 LF with mixed filler
        drive_col(P_LFR, 4'hF); step(); step();
        check("R7", "lf flag set", 32'(lf_seen), 32'd1);
        check("R7", "rf stays clear", 32'(rf_seen), 32'd0);

        // R8 restart by a single column of the same kind
        run_quiet(40);
        drive_col(P_LF, 4'hF); step();
        run_quiet(63);
        check("R8", "lf after restart+63", 32'(lf_seen), 32'd1);
        run_quiet(1);
        check("R8", "lf after restart+64", 32'(lf_seen), 32'd0);

        // R7 all-lanes placement is also local fault
        drive_col(P_ALL, 4'hF); step(); step();
        check("R7", "all-lanes lf flag", 32'(lf_seen), 32'd1);
        check("R7", "all-lanes not rf", 32'(rf_seen), 32'd0);

        // R6 code without control bits is not a fault column
        run_quiet(64);
        drive_col(P_RF, 4'h7); step(); step();
        check("R6", "missing ctrl bit", 32'(rf_seen), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule